// File: doc/BRIEF.md
# Minimal Memory-Mapped Serial Port

This block is a compact serial port that sits on a simple 32-bit register bus. It exposes two word registers. The data word starts a transmit when written and holds the most recently received character when read. The divisor word sets the bit timing. Characters travel as 8N1 frames: one low start bit, eight data bits sent least significant bit first, and one high stop bit.

The block has no status or control register. Software learns about events only from two interrupt outputs. Each of them pulses high for a single clock, one when a transmitted frame has fully left the line and one when a good frame has arrived. One serial bit lasts the divisor value plus one system clocks. The receiver passes its input through a synchronizer. It then samples each bit near its middle, with timing counted from the falling edge of the start bit.

Top module: `mini_uart`

## Requirements
- R1: The bus address carries byte-address bits [ADDR_W-1:2] as a word index. Index 0 reads back the last received character in bits [7:0] with bits [31:8] zero. Index 1 reads back the divisor.
- R2: After reset the data and divisor registers both read zero, the serial output is high, and both interrupt outputs are low.
- R3: A bus write to index 1 stores all 32 bits of the write data as the divisor.
- R4: A bus write to index 0 while the transmitter is idle sends bits [7:0] of the write data and ignores the upper bits. The frame is a start bit of 0, then data bit 0 through bit 7, then a stop bit of 1. Each bit lasts divisor+1 clocks, and the start bit appears in the clock after the write edge. The line is high when idle.
- R5: A bus write to index 0 while a frame is being sent has no effect on that frame.
- R6: The transmit interrupt is high for exactly one clock: the first clock after the stop bit has lasted its full period.
- R7: When a frame with a high stop bit arrives, its character is loaded into the data register and the receive interrupt is high for exactly one clock.
- R8: A frame whose stop bit samples low is dropped. The data register keeps its value and no receive interrupt is raised.
- R9: A low pulse on the receive line that ends before the middle of the start bit is rejected as a false start. It produces no interrupt and no data change.
- R10: Reads at index 2 or higher return zero. Writes there change neither register and start no transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W-2 | Word index (byte address bits [ADDR_W-1:2]) |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| uart_txd | output | 1 | Serial transmit line |
| uart_rxd | input | 1 | Serial receive line |
| irq_tx | output | 1 | One-clock pulse when a frame has been fully sent |
| irq_rx | output | 1 | One-clock pulse when a good frame has been received |

## Verification
The hardest cases to reach are on the receive side: a low stop bit and a start pulse too short to last until the middle of the start bit. Neither can be seen on any output except as a missing interrupt and an unchanged data word. The bench therefore drives the receive line bit by bit with its own timing. It lays down a good frame first, so that the data register holds a known value. It then sends the bad frame and the glitch, and counts receive pulses and reads the data word after each one. The write that lands in the middle of a frame is placed at a chosen clock inside the transmit loop. This lets the line model show whether the frame was disturbed.

// File: rtl/mini_uart_pkg.sv
package mini_uart_pkg;
  localparam int WORD_W  = 32;
  localparam int CHAR_W  = 8;
  localparam int FRAME_W = CHAR_W + 2;
  localparam int IDX_CW  = $clog2(FRAME_W + 1);

  // full serial frame, bit 0 leaves the line first
  function automatic logic [FRAME_W-1:0] frame_of(input logic [CHAR_W-1:0] ch);
    return {1'b1, ch, 1'b0};
  endfunction

  // clocks from start-bit detection to the start-bit sample point
  function automatic logic [WORD_W-1:0] half_period(input logic [WORD_W-1:0] div);
    return div >> 1;
  endfunction
endpackage

// File: rtl/mini_uart_tx.sv
module mini_uart_tx
  import mini_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAR_W-1:0] start_char,
  input  logic [WORD_W-1:0] div,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  logic [FRAME_W-1:0] shreg;
  logic [WORD_W-1:0]  cnt, period;
  logic [IDX_CW-1:0]  idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '1;
      cnt    <= '0;
      period <= '0;
      idx    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          shreg  <= frame_of(start_char);
          period <= div;
          cnt    <= '0;
          idx    <= '0;
          busy   <= 1'b1;
        end
      end else if (cnt == period) begin
        cnt <= '0;
        if (idx == IDX_CW'(FRAME_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          idx   <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign txd = busy ? shreg[0] : 1'b1;

  // R6
  tx_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  tx_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt != period) |=> (busy && $stable(shreg)));
endmodule

// File: rtl/mini_uart_rx.sv
module mini_uart_rx
  import mini_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [WORD_W-1:0] div,
  output logic              valid,
  output logic [CHAR_W-1:0] rx_char
);
  typedef enum logic {RX_IDLE, RX_RUN} rx_state_t;
  rx_state_t          state;
  logic               s1, s2, s3;
  logic [WORD_W-1:0]  cnt, target, period;
  logic [IDX_CW-1:0]  idx;
  logic [CHAR_W-1:0]  shreg;
  wire                fall_seen = s3 && !s2;
  wire                sample_now = (state == RX_RUN) && (cnt == target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s1, s2, s3} <= 3'b111;
      state   <= RX_IDLE;
      cnt     <= '0;
      target  <= '0;
      period  <= '0;
      idx     <= '0;
      shreg   <= '0;
      rx_char <= '0;
      valid   <= 1'b0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
      valid <= 1'b0;
      case (state)
        RX_IDLE: if (fall_seen) begin
          state  <= RX_RUN;
          cnt    <= '0;
          idx    <= '0;
          period <= div;
          target <= half_period(div);
        end
        RX_RUN: if (sample_now) begin
          cnt    <= '0;
          target <= period;
          idx    <= idx + 1'b1;
          if (idx == '0) begin
            if (s2) state <= RX_IDLE;            // false start
          end else if (idx == IDX_CW'(FRAME_W - 1)) begin
            state <= RX_IDLE;
            if (s2) begin
              valid   <= 1'b1;
              rx_char <= shreg;
            end
          end else begin
            shreg <= {s2, shreg[CHAR_W-1:1]};
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R7
  rx_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R8
  rx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(s2));
endmodule

// File: rtl/mini_uart.sv
module mini_uart
  import mini_uart_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              uart_txd,
  input  logic              uart_rxd,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int IDX_W = ADDR_W - 2;

  logic [WORD_W-1:0] div_q;
  logic [CHAR_W-1:0] rx_q;
  logic              tx_busy, rx_valid;
  logic [CHAR_W-1:0] rx_char;

  wire hit_data = (bus_addr == IDX_W'(0));
  wire hit_div  = (bus_addr == IDX_W'(1));
  wire wr_data  = bus_wr && hit_data;
  wire wr_div   = bus_wr && hit_div;
  wire wr_none  = bus_wr && !hit_data && !hit_div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      rx_q  <= '0;
    end else begin
      if (wr_div)   div_q <= bus_wdata;
      if (rx_valid) rx_q  <= rx_char;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_data)     bus_rdata = {{(WORD_W-CHAR_W){1'b0}}, rx_q};
    else if (hit_div) bus_rdata = div_q;
  end

  mini_uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start(wr_data), .start_char(bus_wdata[CHAR_W-1:0]),
    .div(div_q), .txd(uart_txd), .busy(tx_busy), .done(irq_tx)
  );

  mini_uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(uart_rxd), .div(div_q),
    .valid(rx_valid), .rx_char(rx_char)
  );

  assign irq_rx = rx_valid;

  // R3
  div_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> (div_q == $past(bus_wdata)));
  // R7
  rx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (rx_q == $past(rx_char)));
  // R10
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_none && !rx_valid) |=> ($stable(div_q) && $stable(rx_q)));
  // R4
  stop_before_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> $past(uart_txd));
  // R5
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && wr_data) |=> (tx_busy || irq_tx));
endmodule

// File: tb/mini_uart_bench.sv
module mini_uart_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:2]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        uart_txd;
  logic        uart_rxd = 1'b1;
  logic        irq_tx, irq_rx;

  int total = 0, failed = 0, rx_pulses = 0, tx_pulses = 0, cycles = 0;
  bit prev_rx = 1'b0;

  always #10 clk = ~clk;

  mini_uart u_mini_uart (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uart_txd(uart_txd),
    .uart_rxd(uart_rxd), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (irq_rx) rx_pulses++;
      if (irq_tx) tx_pulses++;
      if (irq_rx && prev_rx) check(0, "R7 rx pulse wider than one clock", 2, 1);
      prev_rx = irq_rx;
    end
    if (cycles > 150000) begin
      check(0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a[3:2]; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a[3:2];
    #2 d = bus_rdata;
  endtask

  // cycle-by-cycle line model for one transmitted frame
  task automatic tx_frame(input logic [31:0] wval, input int div, input bit mid_write);
    logic [9:0] fr;
    int errs = 0;
    fr = {1'b1, wval[7:0], 1'b0};
    bus_write(4'h0, wval);
    for (int b = 0; b < 10; b++)
      for (int k = 0; k <= div; k++) begin
        @(negedge clk);
        if (uart_txd !== fr[b] || irq_tx !== 1'b0) errs++;
        bus_wr = 1'b0;
        if (mid_write && b == 4 && k == 0) begin
          bus_addr = 2'd0; bus_wdata = 32'hFF; bus_wr = 1'b1;
        end
      end
    if (mid_write) check(errs == 0, "R5 frame disturbed by mid write", errs, 0);
    else           check(errs == 0, "R4 line mismatch", errs, 0);
    @(negedge clk);
    check(irq_tx === 1'b1 && uart_txd === 1'b1, "R6 tx pulse after stop", {irq_tx, uart_txd}, 2'b11);
    @(negedge clk);
    check(irq_tx === 1'b0, "R6 tx pulse one clock", irq_tx, 0);
  endtask

  task automatic rx_frame(input logic [7:0] ch, input bit stop, input int div);
    logic [9:0] fr;
    fr = {stop, ch, 1'b0};
    for (int b = 0; b < 10; b++) begin
      @(negedge clk);
      uart_rxd = fr[b];
      repeat (div) @(negedge clk);
    end
    @(negedge clk);
    uart_rxd = 1'b1;
    repeat (2 * (div + 1) + 6) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    bus_read(4'h0, rd); check(rd == 0, "R2 data after reset", rd, 0);
    bus_read(4'h4, rd); check(rd == 0, "R2 divisor after reset", rd, 0);
    check(uart_txd === 1'b1 && irq_tx === 1'b0 && irq_rx === 1'b0, "R2 idle outputs",
          {uart_txd, irq_tx, irq_rx}, 3'b100);
    // R3 full-width divisor
    bus_write(4'h4, 32'hDEAD_BEEF);
    bus_read(4'h4, rd); check(rd == 32'hDEAD_BEEF, "R3 divisor readback", rd, 32'hDEAD_BEEF);
    // R4 transmit, upper bits ignored, two divisors
    bus_write(4'h4, 32'd3);
    tx_frame(32'hABCD_12A5, 3, 1'b0);
    tx_frame(32'h0000_003C, 3, 1'b1);
    bus_write(4'h4, 32'd0);
    tx_frame(32'h0000_0081, 0, 1'b0);
    // R7 reception and R1 zero-extended read
    bus_write(4'h4, 32'd7);
    p0 = rx_pulses;
    rx_frame(8'h5A, 1'b1, 7);
    check(rx_pulses - p0 == 1, "R7 one rx pulse", rx_pulses - p0, 1);
    bus_read(4'h0, rd); check(rd == 32'h5A, "R1 data readback", rd, 32'h5A);
    // R8 low stop bit
    p0 = rx_pulses;
    rx_frame(8'hC3, 1'b0, 7);
    check(rx_pulses == p0, "R8 no pulse on bad stop", rx_pulses - p0, 0);
    bus_read(4'h0, rd); check(rd == 32'h5A, "R8 data kept", rd, 32'h5A);
    // R9 short glitch
    p0 = rx_pulses;
    @(negedge clk); uart_rxd = 1'b0;
    repeat (2) @(negedge clk); uart_rxd = 1'b1;
    repeat (40) @(negedge clk);
    check(rx_pulses == p0, "R9 glitch pulse", rx_pulses - p0, 0);
    bus_read(4'h0, rd); check(rd == 32'h5A, "R9 data kept", rd, 32'h5A);
    // R7 second divisor
    bus_write(4'h4, 32'd4);
    p0 = rx_pulses;
    rx_frame(8'h96, 1'b1, 4);
    check(rx_pulses - p0 == 1, "R7 pulse at divisor 4", rx_pulses - p0, 1);
    bus_read(4'h0, rd); check(rd == 32'h96, "R7 data at divisor 4", rd, 32'h96);
    // R10 out-of-range
    p0 = tx_pulses;
    bus_write(4'h8, 32'h1234_5678);
    bus_write(4'hC, 32'h0000_0055);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (uart_txd !== 1'b1) check(0, "R10 stray write started tx", uart_txd, 1);
    end
    check(tx_pulses == p0, "R10 no tx pulse", tx_pulses - p0, 0);
    bus_read(4'h8, rd); check(rd == 0, "R10 read index 2", rd, 0);
    bus_read(4'hC, rd); check(rd == 0, "R10 read index 3", rd, 0);
    bus_read(4'h4, rd); check(rd == 32'd4, "R10 divisor kept", rd, 4);
    bus_read(4'h0, rd); check(rd == 32'h96, "R10 data kept", rd, 32'h96);
    finish_run();
  end
endmodule